// File: doc/BRIEF.md
# Attribute-Typed Control Register Bank

This block holds a handful of control and status words whose bits each follow one access rule. Some bits latch hardware events and stay set until software clears them by writing 1. Others hold configuration that software can change only while a global unlock bit is open, and that configuration survives a hot reset. One word carries a self-clearing qualifier bit: a write updates the rest of that word only when the qualifier is written as 1. Every bit outside a defined field reads as zero and ignores writes.

Software reaches the bank through a plain synchronous port: address, write strobe and a full-word write. Reads are combinational from the address. A fundamental reset clears everything. A hot reset clears all fields except the lock-protected ones.

Word map (default widths): address 0x0 holds the unlock bit at bit 0. Address 0x1 holds the event status, bits [7:0]. Address 0x2 holds the lock-protected configuration, bits [15:0]. Address 0x3 holds the qualified control, bits [11:0], with the qualifier at bit 31.

Top module: `ctlbank`

## Requirements
- R1: A status bit at 0x1 becomes 1 on the clock edge after its `hw_event` bit is 1. It then stays 1 until software clears it. Hardware never clears it.
- R2: A write to 0x1 clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R3: When a hardware event and a software clear hit the same status bit on the same edge, the bit ends at 1.
- R4: The configuration at 0x2 takes a write only while the unlock bit (0x0 bit 0) is 1. While the unlock bit is 0, a write to 0x2 leaves it unchanged.
- R5: The configuration at 0x2 keeps its value through a hot reset. It is cleared to 0 only by the fundamental reset.
- R6: The unlock bit is a plain read/write bit at 0x0 bit 0. It can always be written, and it is cleared to 0 by either reset.
- R7: Bit 31 of 0x3 always reads 0. A write to 0x3 with bit 31 set loads bits [11:0]. A write with bit 31 clear leaves them unchanged.
- R8: Bits outside the defined fields of mapped words always read 0, and data written to them is discarded.
- R9: Addresses other than 0x0 to 0x3 read all zeros. Writes to them change no mapped word.
- R10: A hot reset clears the status, the qualified control and the unlock bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_fund_n | input | 1 | Fundamental reset, synchronous, active low; clears all state |
| rst_hot_n | input | 1 | Hot reset, synchronous, active low; spares lock-protected state |
| addr | input | 4 | Word address |
| wr_en | input | 1 | Write strobe for the addressed word |
| wdata | input | 32 | Write data |
| hw_event | input | 8 | Per-bit set requests for the status word |
| rdata | output | 32 | Read data of the addressed word |

## Verification
The bench aims a hardware event and a software clear at the same status bit on one edge. A design that lets the clear win would lose the event and read 0. It writes the configuration while locked and right after unlocking. A missing or inverted gate would either accept the locked write or drop the unlocked one. It writes the qualified word with the qualifier clear, and a design that ignores the qualifier would load the low field. It issues a hot reset with configuration loaded, and a design that wires the configuration to the wrong reset would read zero afterwards. Random traffic that includes unmapped addresses and stray high bits would expose any bit that stores or returns data it should discard.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int QUAL_BIT = DATA_W - 1;

  typedef logic [DATA_W-1:0] word_t;

  localparam logic [ADDR_W-1:0] A_SWCTL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EVSTAT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOCKCFG = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_QCTL    = ADDR_W'(3);

  // Mask with the low w bits set.
  function automatic word_t low_mask(input int w);
    word_t m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < w);
    return m;
  endfunction

  // Next value of a clear-on-one bit group: set has priority over clear.
  function automatic word_t rw1c_next(input word_t q, input word_t set, input word_t clr);
    return (q & ~clr) | set;
  endfunction
endpackage

// File: rtl/ctlbank_rw1c.sv
module ctlbank_rw1c #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  import ctlbank_pkg::*;

  logic [W-1:0] clr_v;
  logic [W-1:0] nxt;
  word_t        nxt_w;

  assign clr_v = wr_hit ? wdata : '0;
  assign nxt_w = rw1c_next(word_t'(q), word_t'(set), word_t'(clr_v));
  assign nxt   = nxt_w[W-1:0];

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt[i];
    end
  end

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(q) & ~$past(clr_v)) & ~q) == '0));
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set) & ~q) == '0));
  // R2
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (((($past(q) ^ q) & ~$past(wdata)) & ~$past(set)) == '0));
endmodule

// File: rtl/ctlbank_lockreg.sv
module ctlbank_lockreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_fund_n,
  input  logic         rst_hot_n,
  input  logic         unlock,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic wr_ok;

  assign wr_ok = wr_hit && unlock && rst_hot_n;

  always_ff @(posedge clk) begin
    if (!rst_fund_n) q <= '0;
    else if (wr_ok)  q <= wdata;
  end

  // R4
  locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_fund_n)
    !unlock |=> $stable(q));
  // R5
  sticky_hot_chk: assert property (@(posedge clk) disable iff (!rst_fund_n)
    !rst_hot_n |=> $stable(q));
endmodule

// File: rtl/ctlbank_qualreg.sv
module ctlbank_qualreg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         qual,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic wr_ok;

  assign wr_ok = wr_hit && qual;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (wr_ok) q <= wdata;
  end

  // R7
  unqualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !qual) |=> $stable(q));
endmodule

// File: rtl/ctlbank.sv
module ctlbank #(
  parameter int STAT_W = 8,
  parameter int LOCK_W = 16,
  parameter int QCTL_W = 12
) (
  input  logic                             clk,
  input  logic                             rst_fund_n,
  input  logic                             rst_hot_n,
  input  logic [ctlbank_pkg::ADDR_W-1:0]   addr,
  input  logic                             wr_en,
  input  logic [ctlbank_pkg::DATA_W-1:0]   wdata,
  input  logic [STAT_W-1:0]                hw_event,
  output logic [ctlbank_pkg::DATA_W-1:0]   rdata
);
  import ctlbank_pkg::*;

  localparam word_t STAT_MASK = low_mask(STAT_W);
  localparam word_t LOCK_MASK = low_mask(LOCK_W);
  localparam word_t QCTL_MASK = low_mask(QCTL_W);

  initial begin
    if (STAT_W > DATA_W || LOCK_W > DATA_W || QCTL_W > DATA_W - 1)
      $error("ctlbank: field width exceeds word");
  end

  // Named internal events.
  logic nonsticky_rst_n;
  logic hit_swctl, hit_stat, hit_lock, hit_qctl;
  logic unlock_q;
  logic [STAT_W-1:0] stat_q;
  logic [LOCK_W-1:0] lock_q;
  logic [QCTL_W-1:0] qctl_q;

  assign nonsticky_rst_n = rst_fund_n && rst_hot_n;
  assign hit_swctl = wr_en && (addr == A_SWCTL);
  assign hit_stat  = wr_en && (addr == A_EVSTAT);
  assign hit_lock  = wr_en && (addr == A_LOCKCFG);
  assign hit_qctl  = wr_en && (addr == A_QCTL);

  always_ff @(posedge clk) begin
    if (!nonsticky_rst_n) unlock_q <= 1'b0;
    else if (hit_swctl)   unlock_q <= wdata[0];
  end

  ctlbank_rw1c #(.W(STAT_W)) u_stat (
    .clk    (clk),
    .rst_n  (nonsticky_rst_n),
    .wr_hit (hit_stat),
    .wdata  (wdata[STAT_W-1:0]),
    .set    (hw_event),
    .q      (stat_q)
  );

  ctlbank_lockreg #(.W(LOCK_W)) u_lock (
    .clk        (clk),
    .rst_fund_n (rst_fund_n),
    .rst_hot_n  (rst_hot_n),
    .unlock     (unlock_q),
    .wr_hit     (hit_lock),
    .wdata      (wdata[LOCK_W-1:0]),
    .q          (lock_q)
  );

  ctlbank_qualreg #(.W(QCTL_W)) u_qctl (
    .clk    (clk),
    .rst_n  (nonsticky_rst_n),
    .wr_hit (hit_qctl),
    .qual   (wdata[QUAL_BIT]),
    .wdata  (wdata[QCTL_W-1:0]),
    .q      (qctl_q)
  );

  always_comb begin
    unique case (addr)
      A_SWCTL:   rdata = word_t'(unlock_q);
      A_EVSTAT:  rdata = word_t'(stat_q)  & STAT_MASK;
      A_LOCKCFG: rdata = word_t'(lock_q)  & LOCK_MASK;
      A_QCTL:    rdata = word_t'(qctl_q)  & QCTL_MASK;
      default:   rdata = '0;
    endcase
  end

  // R10
  unlock_hot_clear_chk: assert property (@(posedge clk) disable iff (!rst_fund_n)
    !rst_hot_n |=> !unlock_q);
  // R6
  unlock_write_chk: assert property (@(posedge clk) disable iff (!nonsticky_rst_n)
    hit_swctl |=> (unlock_q == $past(wdata[0])));
  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!nonsticky_rst_n)
    (wr_en && addr > A_QCTL) |=> ($stable(lock_q) && $stable(qctl_q) && $stable(unlock_q)));
endmodule

// File: tb/test_ctlbank.sv
`timescale 1ns/1ps
module test_ctlbank;
  logic        clk = 1'b0;
  logic        rst_fund_n = 1'b0;
  logic        rst_hot_n = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  hw_event = '0;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model state.
  bit          m_unl;
  logic [7:0]  m_stat;
  logic [15:0] m_lock;
  logic [11:0] m_qctl;

  always #2 clk = ~clk;

  ctlbank i_ctlbank (
    .clk(clk), .rst_fund_n(rst_fund_n), .rst_hot_n(rst_hot_n),
    .addr(addr), .wr_en(wr_en), .wdata(wdata), .hw_event(hw_event), .rdata(rdata)
  );

  function automatic logic [31:0] expect_rd(input logic [3:0] a);
    case (a)
      4'd0: return {31'd0, m_unl};
      4'd1: return {24'd0, m_stat};
      4'd2: return {16'd0, m_lock};
      4'd3: return {20'd0, m_qctl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R6";
      4'd1: return "R1";
      4'd2: return "R4";
      4'd3: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_edge(input logic [3:0] a, input bit we, input logic [31:0] d,
                            input logic [7:0] ev, input bit hot_n, input bit fund_n);
    if (!fund_n) begin
      m_unl = 0; m_stat = 0; m_lock = 0; m_qctl = 0;
    end else if (!hot_n) begin
      m_unl = 0; m_stat = 0; m_qctl = 0;
    end else begin
      if (we && a == 4'd1) m_stat = m_stat & ~d[7:0];
      m_stat = m_stat | ev;
      if (we && a == 4'd2 && m_unl) m_lock = d[15:0];
      if (we && a == 4'd3 && d[31]) m_qctl = d[11:0];
      if (we && a == 4'd0) m_unl = d[0];
    end
  endtask

  task automatic step(input logic [3:0] a, input bit we, input logic [31:0] d,
                      input logic [7:0] ev, input bit hot_n, input bit fund_n);
    @(negedge clk);
    addr = a; wr_en = we; wdata = d; hw_event = ev; rst_hot_n = hot_n; rst_fund_n = fund_n;
    @(posedge clk);
    model_edge(a, we, d, ev, hot_n, fund_n);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk);
    addr = a; wr_en = 1'b0; hw_event = '0; rst_hot_n = 1'b1; rst_fund_n = 1'b1;
    #1;
    check(req, rdata, expect_rd(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // Fundamental reset: everything zero (R5, R10).
    step(4'd0, 0, 0, 0, 1, 0);
    step(4'd0, 0, 0, 0, 1, 0);
    rd(4'd0, "R6"); check("R6 reset", rdata, 32'd0);
    rd(4'd1, "R10"); rd(4'd2, "R5"); rd(4'd3, "R10");

    // R1: event sets, then holds with no clear.
    step(4'd0, 0, 0, 8'h05, 1, 1);
    rd(4'd1, "R1"); check("R1 set", rdata, 32'h05);
    step(4'd0, 0, 0, 0, 1, 1); step(4'd2, 1, 0, 0, 1, 1);
    rd(4'd1, "R1 hold");
    // R2: zero write keeps, one write clears.
    step(4'd1, 1, 32'h0000_0000, 0, 1, 1);
    rd(4'd1, "R2"); check("R2 zero write", rdata, 32'h05);
    step(4'd1, 1, 32'hFFFF_FF01, 0, 1, 1);
    rd(4'd1, "R2"); check("R2 clear", rdata, 32'h04);
    // R3: set and clear on the same edge.
    step(4'd1, 1, 32'h04, 8'h04, 1, 1);
    rd(4'd1, "R3"); check("R3 set wins", rdata, 32'h04);

    // R4: locked write ignored, unlocked write taken.
    step(4'd2, 1, 32'h0000_ABCD, 0, 1, 1);
    rd(4'd2, "R4"); check("R4 locked", rdata, 32'h0);
    step(4'd0, 1, 32'hFFFF_FFFF, 0, 1, 1);
    rd(4'd0, "R8"); check("R6 R8 swctl", rdata, 32'h1);
    step(4'd2, 1, 32'hFFFF_1234, 0, 1, 1);
    rd(4'd2, "R8"); check("R4 unlocked", rdata, 32'h1234);

    // R7: qualifier gating and reading zero.
    step(4'd3, 1, 32'h0000_0ABC, 0, 1, 1);
    rd(4'd3, "R7"); check("R7 unqualified", rdata, 32'h0);
    step(4'd3, 1, 32'h8000_0ABC, 0, 1, 1);
    rd(4'd3, "R7"); check("R7 qualified", rdata, 32'h0ABC);
    step(4'd3, 1, 32'hFFFF_FFFF, 0, 1, 1);
    rd(4'd3, "R8"); check("R8 qctl high bits", rdata, 32'h0FFF);

    // R9: unmapped write and read.
    step(4'd7, 1, 32'hFFFF_FFFF, 0, 1, 1);
    rd(4'd7, "R9"); check("R9 unmapped", rdata, 32'h0);
    rd(4'd3, "R9"); rd(4'd2, "R9"); rd(4'd0, "R9");

    // R5 / R10: hot reset.
    step(4'd0, 0, 0, 8'hFF, 1, 1);
    step(4'd0, 0, 0, 8'h00, 0, 1);
    rd(4'd2, "R5"); check("R5 sticky", rdata, 32'h1234);
    rd(4'd1, "R10"); check("R10 status", rdata, 32'h0);
    rd(4'd3, "R10"); check("R10 qctl", rdata, 32'h0);
    rd(4'd0, "R10"); check("R10 unlock", rdata, 32'h0);
    step(4'd0, 0, 0, 0, 1, 0);
    rd(4'd2, "R5"); check("R5 fundamental", rdata, 32'h0);

    // Random traffic against the model.
    for (int it = 0; it < 4000; it++) begin
      logic [3:0]  a;
      logic [31:0] d;
      logic [7:0]  ev;
      bit we, hot_n, fund_n;
      a      = 4'($urandom % 8);
      d      = $urandom;
      if (($urandom % 3) == 0) d[31] = 1'b1;
      we     = ($urandom % 3) != 0;
      ev     = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      hot_n  = ($urandom % 64) != 0;
      fund_n = ($urandom % 700) != 0;
      step(a, we, d, ev, hot_n, fund_n);
      begin
        logic [3:0] ra;
        ra = 4'($urandom % 8);
        rd(ra, tag_of(ra));
      end
    end
    finish_run();
  end
endmodule